// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a bank of eleven 32-bit configuration words on a plain word-access register bus. The bus has an address, a write strobe, write data and a combinational read-data return. Every word has its own reset value. Each bit follows one of five access policies:

- ordinary read/write;
- reserved, which always reads 0 and ignores writes;
- set-only, which stays 1 until reset once it has been written to 1;
- clear-only, which can be cleared by writing 0 and never set again by writing 1;
- a status flag that hardware raises, that software clears by writing 1, and that a software write can never set.

Four of the words choose interrupt sources. Their low halves are exported as a flat vector to a separate source multiplexer, which is not part of this block. A single-cycle hardware pulse raises the flag in the second configuration word.

There is no state machine: the register cells update once per clock from the decoded write strobe, and the read path is purely combinational. The two low address bits are ignored, so every access is a whole word. Byte enables, error responses and the functions that the bits control are outside the block.

Top module: `cfgrf_top`

## Requirements
- R1: After reset, word 1 (byte offset 0x04) reads 0x7C000001 and every other word reads 0x00000000.
- R2: In word 0 (offset 0x00) only the bits in mask 0x00000107 store written data; every other bit reads 0.
- R3: In word 1 (offset 0x04) the bits in mask 0xFCFF0101 hold data and the rest read 0. Writing 0x7F00FEFF from reset leaves the word reading 0x7C000001.
- R4: Bit 0 of word 1 resets to 1. A write of 0 clears it, and a later write of 1 leaves it at 0.
- R5: Words 2 to 5 (offsets 0x08, 0x0C, 0x10, 0x14) keep their low 16 bits and read 0 in bits 31:16. Word 2+k drives `sel_words[16k+15:16k]`.
- R6: Word 9 (offset 0x24) keeps its low 8 bits and reads 0 above them. Word 6 (offset 0x18) reads 0 always and ignores writes.
- R7: Bits 3:0 of word 7 (offset 0x1C) are set-only: once written to 1 they stay 1 when 0 is written, until reset. Its other bits except bit 8 read 0.
- R8: Bit 8 of word 7 is set by a high `flag_set_pulse` at a clock edge. A software write of 1 clears it and a software write can never set it. If a pulse and a clearing write arrive at the same edge, the pulse wins.
- R9: Every bit of word 8 (offset 0x20) and word 10 (offset 0x28) is set-only. Writing all ones and then all zeros leaves 0xFFFFFFFF until reset.
- R10: Word indices 11 and above (offset 0x2C upward) read 0, and writes to them change no word. Address bits 1:0 are ignored.
- R11: A write takes effect at the clock edge where `bus_we` is high. `bus_rdata` shows the word selected by `bus_addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| flag_set_pulse | input | 1 | Hardware request that raises bit 8 of word 7 |
| sel_words | output | 64 | Low halves of the four source-select words, word 2 in the lowest bits |

## Verification
Reads are combinational, so the bench samples `bus_rdata` one time unit after it drives the address at a falling edge. A write or a flag pulse shows up from the rising edge that captures it onward. The bench therefore drives a write at a falling edge, lets one rising edge pass, and reads back at the next falling edge. For R11 it also samples before that edge and checks that the old value is still shown. `sel_words` is compared at the same falling-edge points, against a bench model that applies each policy at every rising edge, including a reset in the middle of the run.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 11;
    localparam int SEL_BASE  = 2;
    localparam int SEL_COUNT = 4;
    localparam int SEL_W     = 16;

    typedef logic [DATA_W-1:0] word_t;

    // Per-word policy: reset value, plain r/w mask, set-only mask,
    // clear-only mask, and hardware-set / write-one-clear flag mask.
    typedef struct packed {
        word_t rst;
        word_t rw;
        word_t so;
        word_t co;
        word_t fl;
    } policy_t;

    function automatic policy_t policy_of(input int idx);
        policy_t p;
        p = '0;
        unique case (idx)
            0: p.rw = 32'h0000_0107;
            1: begin
                p.rst = 32'h7C00_0001;
                p.rw  = 32'hFCFF_0100;
                p.co  = 32'h0000_0001;
            end
            2, 3, 4, 5: p.rw = 32'h0000_FFFF;
            7: begin
                p.so = 32'h0000_000F;
                p.fl = 32'h0000_0100;
            end
            8, 10: p.so = 32'hFFFF_FFFF;
            9: p.rw = 32'h0000_00FF;
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/cfgrf_addr_decode.sv
module cfgrf_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 11,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    output logic [IDX_W-1:0]    word_idx,
    output logic                word_valid,
    output logic [NUM_REGS-1:0] wr_hit
);
    assign word_idx   = addr[ADDR_W-1:2];
    assign word_valid = (word_idx <= IDX_W'(NUM_REGS - 1));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign wr_hit[i] = we && word_valid && (word_idx == IDX_W'(i));
    end
endmodule

// File: rtl/cfgrf_reg_cell.sv
module cfgrf_reg_cell
    import cfgrf_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t RW_M    = '0,
    parameter word_t SO_M    = '0,
    parameter word_t CO_M    = '0,
    parameter word_t FL_M    = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  word_t wr_data,
    input  word_t hw_set,
    output word_t q
);
    word_t nxt;

    always_comb begin
        nxt = q;
        if (wr_hit) begin
            nxt = (wr_data & RW_M)
                | ((q | wr_data) & SO_M)
                | (q & wr_data & CO_M)
                | (q & ~wr_data & FL_M);
        end
        nxt = nxt | (hw_set & FL_M);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
    end

    // Set-only bits never fall while out of reset
    assert_set_only_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q & $past(q) & SO_M) == '0));

    // Clear-only bits never rise while out of reset
    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~$past(q) & CO_M) == '0));

    // A flag bit only rises when hardware asked for it
    assert_flag_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~$past(q) & ~$past(hw_set) & FL_M) == '0));

    // A hardware request always leaves the flag high
    assert_flag_hw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & FL_M) != '0) |=> ((q & FL_M) == FL_M));
endmodule

// File: rtl/cfgrf_read_mux.sv
module cfgrf_read_mux
    import cfgrf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                word_idx,
    input  logic                            word_valid,
    output word_t                           rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (word_valid && (word_idx == IDX_W'(i))) rdata = rdata | regs[i];
        end
    end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       flag_set_pulse,
    output logic [SEL_COUNT*SEL_W-1:0] sel_words
);
    logic [IDX_W-1:0]                word_idx;
    logic                            word_valid;
    logic [NUM_REGS-1:0]             wr_hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    cfgrf_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr       (bus_addr),
        .we         (bus_we),
        .word_idx   (word_idx),
        .word_valid (word_valid),
        .wr_hit     (wr_hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam policy_t P = policy_of(i);
        cfgrf_reg_cell #(
            .RST_VAL (P.rst),
            .RW_M    (P.rw),
            .SO_M    (P.so),
            .CO_M    (P.co),
            .FL_M    (P.fl)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[i]),
            .wr_data (bus_wdata),
            .hw_set  ({DATA_W{flag_set_pulse}} & P.fl),
            .q       (regs[i])
        );
    end

    cfgrf_read_mux #(.IDX_W(IDX_W)) u_rmux (
        .regs       (regs),
        .word_idx   (word_idx),
        .word_valid (word_valid),
        .rdata      (bus_rdata)
    );

    for (genvar k = 0; k < SEL_COUNT; k++) begin : g_sel
        assign sel_words[k*SEL_W +: SEL_W] = regs[SEL_BASE+k][SEL_W-1:0];
    end

    // Writes outside the map leave every word untouched
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !word_valid && !flag_set_pulse) |=> $stable(regs));

    // Unmapped reads return zero
    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (bus_rdata == '0));

    // Select-word upper halves never hold data
    assert_sel_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[SEL_BASE][DATA_W-1:SEL_W] == '0) && (regs[SEL_BASE+SEL_COUNT-1][DATA_W-1:SEL_W] == '0));
endmodule

// File: tb/tb_cfgrf_top.sv
`timescale 1ns/1ps
module tb_cfgrf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flag_set_pulse = 1'b0;
    logic [63:0] sel_words;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp [11];

    always #2 clk = ~clk;

    cfgrf_top #(.ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_set_pulse(flag_set_pulse), .sel_words(sel_words)
    );

    function automatic logic [31:0] model_next(int idx, logic [31:0] q, logic [31:0] d, bit wr, bit hw);
        logic [31:0] r;
        r = q;
        if (wr) begin
            case (idx)
                0: r = d & 32'h0000_0107;
                1: r = (d & 32'hFCFF_0100) | (q & d & 32'h1);
                2, 3, 4, 5: r = d & 32'h0000_FFFF;
                7: r = ((q | d) & 32'hF) | (q & ~d & 32'h100);
                8, 10: r = q | d;
                9: r = d & 32'h0000_00FF;
                default: r = q;
            endcase
        end
        if (idx == 7 && hw) r[8] = 1'b1;
        return r;
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 5: return "R5";
            6, 9: return "R6";
            7: return "R7";
            8, 10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 11; i++) exp[i] = (i == 1) ? 32'h7C00_0001 : 32'h0;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] want);
        checks++;
        if (act !== want) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, want);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        flag_set_pulse = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d, bit hw);
        @(negedge clk);
        bus_addr = a;
        bus_we = 1'b1;
        bus_wdata = d;
        flag_set_pulse = hw;
        @(posedge clk);
        for (int i = 0; i < 11; i++)
            exp[i] = model_next(i, exp[i], d, (int'(a[7:2]) == i), hw);
    endtask

    task automatic hw_pulse();
        @(negedge clk);
        bus_we = 1'b0;
        flag_set_pulse = 1'b1;
        @(posedge clk);
        exp[7][8] = 1'b1;
    endtask

    task automatic read_check(logic [7:0] a, logic [31:0] want, string tag);
        @(negedge clk);
        bus_we = 1'b0;
        flag_set_pulse = 1'b0;
        bus_addr = a;
        #1;
        check(tag, {32'h0, bus_rdata}, {32'h0, want});
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 16; i++)
            read_check(8'(i * 4), (i < 11) ? exp[i] : 32'h0, tag);
        check({tag, " sel_words"}, sel_words,
              {exp[5][15:0], exp[4][15:0], exp[3][15:0], exp[2][15:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        read_check(8'h04, 32'h7C00_0001, "R1 word1");
        read_check(8'h00, 32'h0, "R1 word0");
        read_check(8'h20, 32'h0, "R1 word8");
        check_all("R1");

        // R2 remap mask
        bus_write(8'h00, 32'hFFFF_FEF8, 1'b0);
        read_check(8'h00, 32'h0, "R2 reserved");
        bus_write(8'h00, 32'hFFFF_FFFF, 1'b0);
        read_check(8'h00, 32'h107, "R2 writable");

        // R3 / R4 config word 1
        bus_write(8'h04, 32'h7F00_FEFF, 1'b0);
        read_check(8'h04, 32'h7C00_0001, "R3 reserved");
        bus_write(8'h04, 32'hFCFF_0101, 1'b0);
        read_check(8'h04, 32'hFCFF_0101, "R3 data");
        bus_write(8'h04, 32'h0, 1'b0);
        read_check(8'h04, 32'h0, "R4 clear");
        bus_write(8'h04, 32'h1, 1'b0);
        read_check(8'h04, 32'h0, "R4 no set");

        // R5 select words
        bus_write(8'h0C, 32'hABCD_1234, 1'b0);
        read_check(8'h0C, 32'h1234, "R5 upper ignored");
        check("R5 export", {48'h0, sel_words[31:16]}, 64'h1234);

        // R6 key and status
        bus_write(8'h24, 32'hFFFF_FFA5, 1'b0);
        read_check(8'h24, 32'hA5, "R6 key");
        bus_write(8'h18, 32'hFFFF_FFFF, 1'b0);
        read_check(8'h18, 32'h0, "R6 status");

        // R8 flag
        bus_write(8'h1C, 32'h100, 1'b0);
        read_check(8'h1C, 32'h0, "R8 sw cannot set");
        hw_pulse();
        read_check(8'h1C, 32'h100, "R8 hw set");
        bus_write(8'h1C, 32'h100, 1'b0);
        read_check(8'h1C, 32'h0, "R8 w1c");
        bus_write(8'h1C, 32'h100, 1'b1);
        read_check(8'h1C, 32'h100, "R8 hw wins");
        bus_write(8'h1C, 32'h100, 1'b0);

        // R7 set-only nibble
        bus_write(8'h1C, 32'hF, 1'b0);
        bus_write(8'h1C, 32'h0, 1'b0);
        read_check(8'h1C, 32'hF, "R7 sticky");

        // R9 protect words
        bus_write(8'h20, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h20, 32'h0, 1'b0);
        read_check(8'h20, 32'hFFFF_FFFF, "R9 word8");
        bus_write(8'h28, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h28, 32'h0, 1'b0);
        read_check(8'h28, 32'hFFFF_FFFF, "R9 word10");

        // R10 unmapped
        bus_write(8'h2C, 32'hFFFF_FFFF, 1'b0);
        read_check(8'h2C, 32'h0, "R10 read");
        bus_write(8'h3E, 32'h5555_5555, 1'b0);
        check_all("R10 no effect");

        // R11 timing: old value before edge, new after
        @(negedge clk);
        bus_addr = 8'h24;
        bus_we = 1'b1;
        bus_wdata = 32'h3C;
        #1;
        check("R11 before edge", {32'h0, bus_rdata}, {32'h0, exp[9]});
        @(posedge clk);
        exp[9] = 32'h3C;
        #1;
        check("R11 after edge", {32'h0, bus_rdata}, 64'h3C);

        // Reset clears sticky bits (R1 / R9)
        do_reset();
        check_all("R1 after reset");

        // Random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit hw;
            a = 8'($urandom_range(0, 63));
            case ($urandom_range(0, 3))
                0: d = 32'hFFFF_FFFF;
                1: d = 32'h0;
                default: d = $urandom;
            endcase
            hw = ($urandom_range(0, 7) == 0);
            bus_write(a, d, hw);
            read_check(a, (a[7:2] < 11) ? exp[a[7:2]] : 32'h0, tag_of(int'(a[7:2])));
            if (n == 300) do_reset();
            if (n % 100 == 99) check_all("R5 R8 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule